// File: doc/BRIEF.md
# OFDM Symbol Sample Repeater

This block sits in front of a fixed-size inverse transform that is always built for the largest supported symbol length. An upstream stage delivers one frequency-domain symbol of run-time length `fft_len`, which is a power of two between 8 and `MAX_FFT_LEN`. The block stores the symbol in full and then replays it end to end until exactly `MAX_FFT_LEN` samples have been produced. The maximum-size transform can then serve the smaller length without any scaling at its input.

The repeat count is `MAX_FFT_LEN / fft_len`. It is derived by a shift of one by the difference of the two base-2 logarithms, so no divider is needed. When `fft_len` equals `MAX_FFT_LEN`, the symbol is passed once. During an expansion the output valid stays high without a gap for all `MAX_FFT_LEN` samples, and a start flag marks the first of them. The block has no handshake. An upstream stage must not start a new symbol until the current expansion has ended. Input that arrives during an expansion is dropped.

Top module: `ofdm_sym_repeater`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `out_start` are low and stay low until a symbol has been captured.
- R2: In the idle state, capture begins only on a cycle where `in_valid` and `in_start` are both high. That sample is stored as index 0. Samples that have `in_valid` high but `in_start` low while idle are dropped and cause no output.
- R3: The whole symbol is stored before any output. If the last (`fft_len`-th) sample is accepted at clock edge k, the first expanded sample with `out_start` high is presented after edge k+1.
- R4: An expanded symbol consists of the stored samples replayed in index order 0 to `fft_len`-1, repeated `MAX_FFT_LEN/fft_len` times. This gives `MAX_FFT_LEN` samples in total, for example 8 copies of an 8-sample symbol when the maximum is 64.
- R5: `out_valid` is high on `MAX_FFT_LEN` consecutive cycles per expanded symbol, with no gap. `out_start` is high only on the first of these cycles.
- R6: When `fft_len` equals `MAX_FFT_LEN`, the symbol is emitted exactly once, in index order.
- R7: While an expansion is in progress, every input is ignored, including `in_start`. The expansion continues unchanged, and no extra expansion follows.
- R8: A sample with `in_start` and `in_valid` high while a capture is still filling restarts the capture. That sample becomes index 0, and the `fft_len` presented with it becomes the symbol length.
- R9: `fft_len` is sampled only on the cycle that carries the start marker. Changes on later cycles do not alter the length of the symbol.
- R10: A reset during an expansion aborts it. `out_valid` is low after the reset edge, and no further samples of that symbol appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_re | input | DATA_W | Real part of the input subcarrier |
| in_im | input | DATA_W | Imaginary part of the input subcarrier |
| in_valid | input | 1 | Input sample qualifier |
| in_start | input | 1 | Marks the first sample of a symbol |
| fft_len | input | $clog2(MAX_FFT_LEN)+1 | Symbol length, a power of two; sampled with the start marker |
| out_re | output | DATA_W | Real part of the expanded sample |
| out_im | output | DATA_W | Imaginary part of the expanded sample |
| out_valid | output | 1 | Output sample qualifier |
| out_start | output | 1 | First sample of an expanded symbol |

## Verification
The bench drives the smallest length, the largest length and two lengths in between, with and without idle gaps while the symbol fills. A repeat count derived incorrectly would show up as a short or long burst, and a wrong replay order as mismatched sample values. A design that emitted samples before the symbol was complete would show an early start flag, and one that dropped valid mid-burst would show a gap inside the burst. The bench also sends a start marker and junk while an expansion runs, stray valid samples while idle, a restart in the middle of a fill, a length change after the start and a reset in the middle of a burst. A design that mishandled any of these would emit stray output, use the wrong length or keep playing after the reset.

// File: rtl/ofdm_rep_pkg.sv
// Package: shared types of the OFDM symbol sample repeater.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ofdm_rep_pkg;

    // Controller phases: waiting for a start, storing a symbol, replaying it.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PLAY = 2'd2
    } rep_state_e;

endpackage

// File: rtl/ofdm_rep_len_decode.sv
// Module: ofdm_rep_len_decode
// Turns a power-of-two symbol length into its last index and the number of
// whole-symbol copies needed to reach MAX_LEN. The copy count is a shift by
// log2(MAX_LEN) - log2(len), so no divider is built.
// Assumes len is a power of two in [8, MAX_LEN]; other values give
// undefined counts.
module ofdm_rep_len_decode #(
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN) + 1,
    parameter int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] last_idx,
    output logic [LEN_W-1:0] reps
);
    localparam int LOG_MAX = $clog2(MAX_LEN);

    logic [LEN_W-1:0] log_len;

    // Priority search for the set bit of the length: its position is log2.
    always_comb begin
        log_len = '0;
        for (int b = 0; b < LEN_W; b++) begin
            if (len[b]) begin
                log_len = LEN_W'(b);
            end
        end
    end

    // Copy count and last index derived from the decoded logarithm.
    always_comb begin
        reps     = LEN_W'(1) << (LEN_W'(LOG_MAX) - log_len);
        last_idx = IDX_W'(len - LEN_W'(1));
    end

endmodule

// File: rtl/ofdm_rep_store.sv
// Module: ofdm_rep_store
// Single-symbol sample memory with one write port and one read port. Read
// data is registered, so it appears one cycle after the read request.
// Assumes the reader never addresses an entry in the same cycle it is
// written; the controller guarantees this because a symbol is complete
// before its replay begins.
module ofdm_rep_store #(
    parameter int DEPTH = 64,
    parameter int WORD_W = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store one sample per write request.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read of the requested entry.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/ofdm_rep_ctrl.sv
// Module: ofdm_rep_ctrl
// Sequencer of the repeater. It latches the symbol length at the start
// marker and steps the write index while the symbol fills. It then steps the
// read index and the copy counter until every copy has been read. Input
// is ignored while replaying. A start marker during a fill restarts capture.
// Assumes last_idx and reps come from a decoder fed by len_q.
module ofdm_rep_ctrl
    import ofdm_rep_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN) + 1,
    parameter int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic [LEN_W-1:0] fft_len,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [LEN_W-1:0] reps,
    output logic [LEN_W-1:0] len_q,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_addr,
    output logic             rd_first
);
    rep_state_e       state;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [LEN_W-1:0] rep;
    logic             take_start;
    logic             fill_last;
    logic             play_last;

    // Decode of this cycle's events.
    always_comb begin
        take_start = in_valid && in_start && (state != ST_PLAY);
        fill_last  = (state == ST_FILL) && in_valid && !in_start && (wr_idx == last_idx);
        play_last  = (state == ST_PLAY) && (rd_idx == last_idx) && (rep == reps - LEN_W'(1));
    end

    // Memory port requests for this cycle.
    always_comb begin
        wr_en    = take_start || ((state == ST_FILL) && in_valid);
        wr_addr  = take_start ? '0 : wr_idx;
        rd_en    = (state == ST_PLAY);
        rd_addr  = rd_idx;
        rd_first = (state == ST_PLAY) && (rd_idx == '0) && (rep == '0);
    end

    // Phase register, length latch and index counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            len_q  <= LEN_W'(MAX_LEN);
            wr_idx <= '0;
            rd_idx <= '0;
            rep    <= '0;
        end else if (take_start) begin
            state  <= ST_FILL;
            len_q  <= fft_len;
            wr_idx <= IDX_W'(1);
        end else begin
            case (state)
                ST_FILL: begin
                    if (fill_last) begin
                        state  <= ST_PLAY;
                        rd_idx <= '0;
                        rep    <= '0;
                    end else if (in_valid) begin
                        wr_idx <= wr_idx + IDX_W'(1);
                    end
                end
                ST_PLAY: begin
                    if (rd_idx == last_idx) begin
                        rd_idx <= '0;
                        rep    <= rep + LEN_W'(1);
                        if (play_last) begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        rd_idx <= rd_idx + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2, R8: the fill index never passes the last entry nor re-enters index 0.
    a_r2_fill_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> ((wr_idx <= last_idx) && (wr_idx != '0)));

    // R4: replay stays inside the stored symbol and the copy count.
    a_r4_play_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY) |-> ((rd_idx <= last_idx) && (rep < reps)));

endmodule

// File: rtl/ofdm_sym_repeater.sv
// Module: ofdm_sym_repeater (top)
// Expands one frequency-domain symbol of run-time length fft_len into
// MAX_FFT_LEN samples by whole-symbol repetition. The symbol is stored first,
// then replayed MAX_FFT_LEN/fft_len times with a continuous valid.
// Assumes fft_len is a power of two in [8, MAX_FFT_LEN] and that a new symbol
// is not started while an expansion runs (such input is dropped).
module ofdm_sym_repeater #(
    parameter int DATA_W      = 16,
    parameter int MAX_FFT_LEN = 64,
    parameter int LEN_W       = $clog2(MAX_FFT_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [LEN_W-1:0]  fft_len,
    output logic [DATA_W-1:0] out_re,
    output logic [DATA_W-1:0] out_im,
    output logic              out_valid,
    output logic              out_start
);
    localparam int IDX_W  = $clog2(MAX_FFT_LEN);
    localparam int WORD_W = 2 * DATA_W;

    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  last_idx;
    logic [LEN_W-1:0]  reps;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr;
    logic              rd_en;
    logic [IDX_W-1:0]  rd_addr;
    logic              rd_first;
    logic [WORD_W-1:0] rd_data;
    logic [LEN_W-1:0]  burst_cnt;

    ofdm_rep_len_decode #(
        .MAX_LEN (MAX_FFT_LEN),
        .LEN_W   (LEN_W),
        .IDX_W   (IDX_W)
    ) len_dec_i (
        .len      (len_q),
        .last_idx (last_idx),
        .reps     (reps)
    );

    ofdm_rep_ctrl #(
        .MAX_LEN (MAX_FFT_LEN),
        .LEN_W   (LEN_W),
        .IDX_W   (IDX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .fft_len  (fft_len),
        .last_idx (last_idx),
        .reps     (reps),
        .len_q    (len_q),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_first (rd_first)
    );

    ofdm_rep_store #(
        .DEPTH  (MAX_FFT_LEN),
        .WORD_W (WORD_W),
        .ADDR_W (IDX_W)
    ) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data ({in_re, in_im}),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Output qualifiers aligned with the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_start <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_start <= rd_first;
        end
    end

    // Split of the stored word into its two parts.
    always_comb begin
        out_re = rd_data[WORD_W-1:DATA_W];
        out_im = rd_data[DATA_W-1:0];
    end

    // Count of samples already emitted in the current burst (checks only).
    always_ff @(posedge clk) begin
        if (!rst_n || !out_valid) begin
            burst_cnt <= '0;
        end else begin
            burst_cnt <= out_start ? LEN_W'(1) : burst_cnt + LEN_W'(1);
        end
    end

    // R5: the start flag only ever marks a valid sample.
    a_r5_start_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> out_valid);

    // R5: a burst begins only after valid has been low.
    a_r5_start_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> !$past(out_valid));

    // R5: valid holds until all MAX_FFT_LEN samples of the burst are out.
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (burst_cnt != LEN_W'(MAX_FFT_LEN - 1))) |=> out_valid);

    // R4: a burst never runs past MAX_FFT_LEN samples.
    a_r4_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_start) |-> ((burst_cnt != '0) && (burst_cnt < LEN_W'(MAX_FFT_LEN))));

endmodule

// File: tb/ofdm_sym_repeater_tb_top.sv
// Scoreboard bench for ofdm_sym_repeater: the driver pushes the expected
// expanded samples into a queue and the monitor pops and compares them.
module ofdm_sym_repeater_tb_top;
    localparam int DATA_W = 16;
    localparam int MAXL   = 64;
    localparam int LEN_W  = $clog2(MAXL) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] in_re = '0;
    logic [DATA_W-1:0] in_im = '0;
    logic              in_valid = 1'b0;
    logic              in_start = 1'b0;
    logic [LEN_W-1:0]  fft_len = LEN_W'(MAXL);
    logic [DATA_W-1:0] out_re;
    logic [DATA_W-1:0] out_im;
    logic              out_valid;
    logic              out_start;

    ofdm_sym_repeater #(.DATA_W(DATA_W), .MAX_FFT_LEN(MAXL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_re(in_re), .in_im(in_im),
        .in_valid(in_valid), .in_start(in_start), .fft_len(fft_len),
        .out_re(out_re), .out_im(out_im), .out_valid(out_valid), .out_start(out_start)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_edge = 0;
    int pos = 0;
    bit in_abort = 1'b0;
    string cur_req = "R1";
    logic [2*DATA_W:0] exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] gen_re(int base, int i);
        return DATA_W'(base + i * 3);
    endfunction
    function automatic logic [DATA_W-1:0] gen_im(int base, int i);
        return DATA_W'(base ^ (i << 4)) ^ 16'h5A5A;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive n samples of a symbol of length len; push the expansion if complete.
    task automatic send(int len, int n, int base, int gap, bit push, int len_after);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_re    = gen_re(base, i);
            in_im    = gen_im(base, i);
            fft_len  = (i == 0) ? LEN_W'(len) : LEN_W'(len_after);
            if (i == n - 1) begin
                @(posedge clk);
                #1 last_edge = cyc;
            end
            if (gap > 0 && i != n - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_start = 1'b0;
                in_re    = 16'hDEAD;
                for (int g = 1; g < gap; g++) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
        if (push && n == len) begin
            for (int r = 0; r < MAXL / len; r++)
                for (int i = 0; i < len; i++)
                    exp_q.push_back({(r == 0 && i == 0), gen_re(base, i), gen_im(base, i)});
        end
    endtask

    task automatic wait_drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, cur_req, "expected samples left undelivered", exp_q.size(), 0);
        repeat (20) @(negedge clk);
    endtask

    // Monitor: compare outputs with the queue, latency, continuity.
    always @(negedge clk) begin
        if (!rst_n || in_abort) begin
            pos = 0;
        end else if (out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "output with nothing expected", int'(out_re), -1);
            end else begin
                logic [2*DATA_W:0] e;
                e = exp_q.pop_front();
                check({out_start, out_re, out_im} == e, cur_req, "sample {start,re,im} (R4/R5)",
                      int'({out_start, out_re, out_im}), int'(e));
                if (out_start)
                    check(cyc == last_edge + 1, "R3", "first output cycle", cyc, last_edge + 1);
            end
            pos++;
            if (pos == MAXL) begin
                check(1'b1, "R5", "burst length", pos, MAXL);
                pos = 0;
            end
        end else if (pos != 0) begin
            check(1'b0, "R5", "valid gap inside burst at sample", pos, MAXL);
            pos = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, cur_req, "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_start == 1'b0, "R1", "out_start in reset", int'(out_start), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R4: smallest length, 8 copies.
        cur_req = "R4";
        send(8, 8, 100, 0, 1'b1, 8);
        wait_drain();

        // R4: length 16 with fill gaps; R9: fft_len changed after start.
        cur_req = "R9";
        send(16, 16, 500, 3, 1'b1, 64);
        wait_drain();

        // R4: length 32.
        cur_req = "R4";
        send(32, 32, 900, 0, 1'b1, 8);
        wait_drain();

        // R6: full length, passed once.
        cur_req = "R6";
        send(64, 64, 2000, 0, 1'b1, 16);
        wait_drain();

        // R2: valid samples without start while idle are dropped.
        cur_req = "R2";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = 1'b0;
            fft_len  = LEN_W'(8);
            in_re    = DATA_W'(i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (80) @(negedge clk);
        check(out_valid == 1'b0, "R2", "idle after stray samples", int'(out_valid), 0);
        send(8, 8, 3000, 1, 1'b1, 8);
        wait_drain();

        // R7: start marker and junk during an expansion are ignored.
        cur_req = "R7";
        send(8, 8, 4000, 0, 1'b1, 8);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i % 8 == 0);
            fft_len  = LEN_W'(8);
            in_re    = 16'hBEEF;
            in_im    = DATA_W'(i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
        wait_drain();
        repeat (80) @(negedge clk);
        check(out_valid == 1'b0, "R7", "no extra expansion", int'(out_valid), 0);

        // R8: restart in mid-fill with a new length.
        cur_req = "R8";
        send(32, 10, 5000, 0, 1'b0, 32);
        send(16, 16, 6000, 0, 1'b1, 32);
        wait_drain();

        // R10: reset during an expansion.
        cur_req = "R10";
        send(8, 8, 7000, 0, 1'b1, 8);
        while (pos < 5) @(negedge clk);
        @(posedge clk);
        #1;
        in_abort = 1'b1;
        rst_n = 1'b0;
        exp_q.delete();
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R10", "out_valid after reset edge", int'(out_valid), 0);
        check(out_start == 1'b0, "R10", "out_start after reset edge", int'(out_start), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 in_abort = 1'b0;
        repeat (100) @(negedge clk);
        check(out_valid == 1'b0, "R10", "aborted symbol stays silent", int'(out_valid), 0);
        send(16, 16, 8000, 0, 1'b1, 16);
        wait_drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule